// File: doc/BRIEF.md
# Move-Triggered Arithmetic and Compare Unit

This block is a single function unit for a processor whose instructions are data transports rather than opcodes. Two move slots can deliver a value to one of the unit's destination addresses in every cycle. Writing the operand address only stores a value. Writing any of the five trigger addresses supplies the second operand and starts an operation. The address written selects the operation: add, subtract, or one of three unsigned compares.

The unit has one pipeline stage. A trigger latches both operands and the operation code. On the next clock edge the result register is loaded and a valid flag rises. The result register drives the unit's source port at all times. Reading it is just a transport and changes nothing. A later move can therefore send the value to a register file, to a one-bit guard register held inside the unit, or straight back into an operand port.

Top module: `tt_alu_unit`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `res_data` is 0, `res_valid` is 0 and `guard` is 0. The stored operand is also 0.
- R2: A move to destination 0 stores its data as the first operand. It starts no operation, and `res_data` and `res_valid` keep their values.
- R3: A move to a trigger destination supplies the second operand B, and the destination selects the operation on the first operand A. Destination 1 gives A+B and destination 2 gives A-B, both modulo 2^W. Destination 3 gives A==B, destination 4 gives A>B and destination 5 gives A<B. The compares are unsigned and return 1 or 0 in the W-bit result.
- R4: After the clock edge that captures a trigger, `res_valid` is 0. After the following edge, `res_data` holds the new result and `res_valid` is 1.
- R5: `res_data` changes only on the edge that completes a triggered operation. While an operation is in flight, the previous result stays readable.
- R6: The operand keeps its value across any number of triggers, so one operand can serve several operations.
- R7: When an operand move and a trigger move arrive in the same cycle, the trigger uses the newly written operand.
- R8: A move to destination 6 loads bit 0 of its data into `guard`. That bit can be taken from a compare result moved out of `res_data`.
- R9: When both slots write the same destination in one cycle, slot 1 wins.
- R10: A move to destination 7, or a slot whose enable is low, changes no state.
- R11: Triggers on consecutive cycles each complete in order, one cycle apart. `res_valid` stays low while a newer trigger is still pending.
- R12: `res_data` can be moved back into the operand port and used by the next trigger with no register-file write in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s0_en | input | 1 | Slot 0 move enable |
| s0_dst | input | 3 | Slot 0 destination address |
| s0_data | input | W | Slot 0 move data |
| s1_en | input | 1 | Slot 1 move enable |
| s1_dst | input | 3 | Slot 1 destination address |
| s1_data | input | W | Slot 1 move data |
| res_data | output | W | Result source port |
| res_valid | output | 1 | Result holds the most recent trigger's outcome |
| guard | output | 1 | Boolean guard register |

## Verification
The key collision is an operand write and a trigger that land in the same cycle, whether on different slots or in either slot order. A second is a fresh trigger arriving on the very edge where the previous operation completes. Directed sequences set up both cases. A long seeded random run also pairs every destination with every other destination across the two slots, so these collisions recur many times. A cycle-level model in the bench applies slot 0 and then slot 1, forwards the new operand into any trigger, and retires pending work one edge later. After every edge it compares the result, the valid flag and the guard against the hardware.

// File: rtl/tt_alu_unit.sv
module tt_alu_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s0_en,
  input  logic [2:0]   s0_dst,
  input  logic [W-1:0] s0_data,
  input  logic         s1_en,
  input  logic [2:0]   s1_dst,
  input  logic [W-1:0] s1_data,
  output logic [W-1:0] res_data,
  output logic         res_valid,
  output logic         guard
);
  localparam int NS = 2;
  localparam logic [2:0] D_OPND = 3'd0, D_ADD = 3'd1, D_SUB = 3'd2,
                         D_EQ = 3'd3, D_GT = 3'd4, D_LT = 3'd5, D_GRD = 3'd6;

  logic [W-1:0] opnd_q, opnd_nx, a_q, b_q, b_nx, res_q, calc;
  logic [2:0]   code_q, code_nx;
  logic         busy_q, vld_q, grd_q, grd_nx, fire;

  logic         en  [NS];
  logic [2:0]   dst [NS];
  logic [W-1:0] dat [NS];

  assign en[0] = s0_en;  assign dst[0] = s0_dst;  assign dat[0] = s0_data;
  assign en[1] = s1_en;  assign dst[1] = s1_dst;  assign dat[1] = s1_data;

  always_comb begin
    opnd_nx = opnd_q;
    b_nx    = b_q;
    code_nx = code_q;
    grd_nx  = grd_q;
    fire    = 1'b0;
    for (int i = 0; i < NS; i++) begin
      if (en[i]) begin
        if (dst[i] == D_OPND) opnd_nx = dat[i];
        else if (dst[i] == D_GRD) grd_nx = dat[i][0];
        else if (dst[i] >= D_ADD && dst[i] <= D_LT) begin
          fire    = 1'b1;
          code_nx = dst[i];
          b_nx    = dat[i];
        end
      end
    end
  end

  always_comb begin
    case (code_q)
      D_ADD:   calc = a_q + b_q;
      D_SUB:   calc = a_q - b_q;
      D_EQ:    calc = W'(a_q == b_q);
      D_GT:    calc = W'(a_q > b_q);
      D_LT:    calc = W'(a_q < b_q);
      default: calc = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opnd_q <= '0;
      a_q    <= '0;
      b_q    <= '0;
      code_q <= D_ADD;
      busy_q <= 1'b0;
      res_q  <= '0;
      vld_q  <= 1'b0;
      grd_q  <= 1'b0;
    end else begin
      opnd_q <= opnd_nx;
      grd_q  <= grd_nx;
      busy_q <= fire;
      if (fire) begin
        a_q    <= opnd_nx;
        b_q    <= b_nx;
        code_q <= code_nx;
      end
      if (busy_q) res_q <= calc;
      vld_q <= fire ? 1'b0 : (busy_q ? 1'b1 : vld_q);
    end
  end

  assign res_data  = res_q;
  assign res_valid = vld_q;
  assign guard     = grd_q;

  assert_start_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !res_valid);

  assert_done_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire ##1 !fire |=> res_valid);

  assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ##1 $stable(res_data));

  assert_operand_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(s0_en && s0_dst == D_OPND) && !(s1_en && s1_dst == D_OPND)) |=> $stable(opnd_q));

  assert_guard_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_en && s1_dst == D_GRD) |=> guard == $past(s1_data[0]));

  assert_bool_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && code_q >= D_EQ) |=> res_data <= W'(1));
endmodule

// File: tb/tt_alu_unit_test.sv
module tt_alu_unit_test;
  localparam int W = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic s0_en = 1'b0, s1_en = 1'b0;
  logic [2:0] s0_dst = '0, s1_dst = '0;
  logic [W-1:0] s0_data = '0, s1_data = '0;
  logic [W-1:0] res_data;
  logic res_valid, guard;

  int checks = 0, fails = 0;
  logic [W-1:0] m_opnd = '0, m_res = '0, m_a = '0, m_b = '0;
  logic [2:0] m_code = 3'd1;
  logic m_pend = 1'b0, m_vld = 1'b0, m_grd = 1'b0;

  tt_alu_unit #(.W(W)) uut (.*);

  always #2 clk = ~clk;

  function automatic logic [W-1:0] calc(input logic [2:0] c, input logic [W-1:0] a, input logic [W-1:0] b);
    case (c)
      3'd1: return a + b;
      3'd2: return a - b;
      3'd3: return (a == b) ? W'(1) : W'(0);
      3'd4: return (a > b) ? W'(1) : W'(0);
      3'd5: return (a < b) ? W'(1) : W'(0);
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic e0, input logic [2:0] d0, input logic [W-1:0] x0,
                      input logic e1, input logic [2:0] d1, input logic [W-1:0] x1);
    logic en[2]; logic [2:0] dd[2]; logic [W-1:0] xx[2];
    logic [W-1:0] nop, tb; logic [2:0] tc; logic tf, ng;
    en[0] = e0; dd[0] = d0; xx[0] = x0; en[1] = e1; dd[1] = d1; xx[1] = x1;
    s0_en = e0; s0_dst = d0; s0_data = x0; s1_en = e1; s1_dst = d1; s1_data = x1;
    nop = m_opnd; tf = 1'b0; tc = m_code; tb = m_b; ng = m_grd;
    for (int i = 0; i < 2; i++)
      if (en[i]) begin
        if (dd[i] == 3'd0) nop = xx[i];
        else if (dd[i] == 3'd6) ng = xx[i][0];
        else if (dd[i] != 3'd7) begin tf = 1'b1; tc = dd[i]; tb = xx[i]; end
      end
    if (m_pend) m_res = calc(m_code, m_a, m_b);
    m_vld = tf ? 1'b0 : (m_pend ? 1'b1 : m_vld);
    m_pend = tf;
    if (tf) begin m_code = tc; m_a = nop; m_b = tb; end
    m_opnd = nop; m_grd = ng;
    @(negedge clk);
    s0_en = 1'b0; s1_en = 1'b0;
    chk({tag, " result"}, res_data, m_res);
    chk({tag, " valid"}, W'(res_valid), W'(m_vld));
    chk({tag, " guard"}, W'(guard), W'(m_grd));
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, 3'd0, '0, 1'b0, 3'd0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset result", res_data, '0);
    chk("R1 reset valid", W'(res_valid), '0);
    chk("R1 reset guard", W'(guard), '0);
    rst_n = 1'b1;
    step("R1 zero operand", 1'b1, 3'd1, 16'd5, 1'b0, 3'd0, '0);
    idle("R1 zero operand sum");
    chk("R1 operand zero after reset", res_data, 16'd5);

    step("R2 operand only", 1'b1, 3'd0, 16'd100, 1'b0, 3'd0, '0);
    chk("R2 no start", W'(res_valid), W'(1));
    idle("R2 idle");

    step("R3 add", 1'b1, 3'd1, 16'd23, 1'b0, 3'd0, '0);
    chk("R4 in flight valid low", W'(res_valid), '0);
    chk("R5 old result visible", res_data, 16'd5);
    idle("R3 add done");
    chk("R3 add value", res_data, 16'd123);
    step("R3 sub wrap", 1'b0, 3'd0, '0, 1'b1, 3'd2, 16'd101); idle("R3 sub done");
    chk("R3 sub wrap value", res_data, 16'hFFFF);
    step("R3 eq", 1'b1, 3'd3, 16'd100, 1'b0, 3'd0, '0); idle("R3 eq done");
    chk("R3 eq true", res_data, 16'd1);
    step("R3 gt", 1'b1, 3'd4, 16'hF000, 1'b0, 3'd0, '0); idle("R3 gt done");
    chk("R3 gt unsigned false", res_data, 16'd0);
    step("R3 lt", 1'b1, 3'd5, 16'hF000, 1'b0, 3'd0, '0); idle("R3 lt done");
    chk("R3 lt unsigned true", res_data, 16'd1);
    chk("R6 operand reused", m_a, 16'd100);

    step("R8 guard from compare", 1'b1, 3'd6, res_data, 1'b0, 3'd0, '0);
    chk("R8 guard set", W'(guard), W'(1));
    step("R7 same cycle", 1'b1, 3'd1, 16'd1, 1'b1, 3'd0, 16'd40); idle("R7 done");
    chk("R7 new operand used", res_data, 16'd41);
    step("R9 slot1 wins", 1'b1, 3'd0, 16'd7, 1'b1, 3'd0, 16'd9);
    step("R9 probe", 1'b1, 3'd1, 16'd0, 1'b0, 3'd0, '0); idle("R9 done");
    chk("R9 slot1 operand", res_data, 16'd9);
    step("R10 dst7 ignored", 1'b1, 3'd7, 16'd55, 1'b1, 3'd7, 16'd66);
    step("R10 probe", 1'b1, 3'd1, 16'd0, 1'b0, 3'd0, '0); idle("R10 done");
    chk("R10 state unchanged", res_data, 16'd9);

    step("R11 first", 1'b1, 3'd1, 16'd1, 1'b0, 3'd0, '0);
    step("R11 second", 1'b1, 3'd2, 16'd1, 1'b0, 3'd0, '0);
    chk("R11 first done valid low", W'(res_valid), '0);
    chk("R11 first result", res_data, 16'd10);
    idle("R11 second done");
    chk("R11 second result", res_data, 16'd8);

    step("R12 forward", 1'b1, 3'd0, res_data, 1'b0, 3'd0, '0);
    step("R12 use", 1'b1, 3'd1, 16'd2, 1'b0, 3'd0, '0); idle("R12 done");
    chk("R12 forwarded operand", res_data, 16'd10);

    void'($urandom(32'd1234));
    for (int k = 0; k < 400; k++) begin
      logic [W-1:0] x0, x1;
      x0 = ($urandom % 4 == 0) ? m_opnd : W'($urandom);
      x1 = W'($urandom % 8);
      step("R11 random", 1'($urandom), 3'($urandom), x0, 1'($urandom), 3'($urandom), x1);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule